// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block models the device side of a 4096-byte serial EEPROM reached over a four-wire SPI link. It watches chip select, serial clock and serial data in from the bus, decodes an 8-bit instruction, takes a 16-bit address, and then either streams stored bytes out or gathers a burst of bytes for a page write. A write does not touch the array while it is being shifted in. The bytes go to a page-sized buffer, and they land in the array in one step when a programmable busy period ends.

The bus pins are asynchronous to the block. They pass through synchronizers that run on a faster system clock, and edge detection on the synchronized serial clock drives all sequencing. A separate protection unit sits beside the engine. It sees the address of each byte being written and answers with a permit bit. The engine exports the two protection-level bits and the guard-enable bit held in its status byte so that unit can decode them. The serial output comes out as a data bit plus an output enable, and a pad tri-state buffer sits outside the block.

Top module: `spi_eeprom_engine`

## Requirements
- R1: Instruction codes are 8 bits: 06h sets the write-enable latch, 04h clears it, 03h reads, 02h writes, 05h reads status, 01h writes status. Set and clear act on the 8th serial-clock rising edge, and further clocks before chip select rises do not undo them.
- R2: Input bits are taken on serial-clock rising edges and output bits change only on falling edges, most significant bit first. A clock that idles low and a clock that idles high both work.
- R3: A read takes a 16-bit address of which the low 12 bits are used. The first data bit is driven on the falling edge after the 24th rising edge. Continued clocking returns the following addresses, and the address wraps from FFFh to 000h.
- R4: A write accepts a burst of bytes into one 32-byte page. Only the low 5 address bits advance, so a 33rd byte overwrites the first byte's slot and bytes never spill into the next page.
- R5: A write or status write is carried out only when chip select rises after the last bit of a complete byte and before the next rising edge. A rise at any other point drops the command: no busy period starts and the write-enable latch keeps its value.
- R6: Write and status write are ignored when the write-enable latch is clear. The latch clears when either of them starts executing.
- R7: Once a write starts, a busy period of BUSY_CYCLES system clocks follows, during which status bit 0 reads 1. Every instruction other than status read is ignored in that period: a read never enables the output, and 06h leaves the latch clear.
- R8: A chip-select fall while the serial clock is high does not sample the input. The first instruction bit is taken on the next rising edge.
- R9: A byte whose address has the permit input low at the moment the byte completes is not stored. Permitted bytes of the same burst are stored.
- R10: After reset every array byte reads FFh, the status byte reads 00h, and the output enable is low. The output enable drops whenever chip select is inactive.
- R11: A status write stores data bit 7 as the guard-enable bit and bits 3:2 as the protection level, and applies them when the busy period ends. The status byte reads {guard, 000b, level[1:0], write-enable latch, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out pad |
| wp_addr | output | ADDR_W | Address of the byte currently being written, for the protection unit |
| wp_permit | input | 1 | High when wp_addr may be written |
| prot_lvl | output | 2 | Protection level from the status byte |
| prot_guard | output | 1 | Guard-enable bit from the status byte |

## Verification
Several properties are checked on every cycle: the output bit holds still except on serial-clock falling edges, the output enable drops while chip select is inactive, the latch is clear whenever a busy period begins, the busy counter stays inside its bound, instructions arriving during a busy period are steered to the ignore state, and a denied byte leaves its buffer slot invalid. Other behaviour spans whole transactions and needs the bench's scenarios to show it. These scenarios cover the commit window against cancelled bursts, wrap within a page and at the top of the array, the 33-byte overwrite, status-write results, per-byte denial by the protection unit, and the idle-high clock case.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ADDR = 3'd1,
        PH_RD   = 3'd2,
        PH_WR   = 3'd3,
        PH_SWR  = 3'd4,
        PH_SRD  = 3'd5,
        PH_IGN  = 3'd6
    } phase_e;

    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_READ      = 8'h03;
    localparam logic [7:0] CMD_WRITE     = 8'h02;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic cs_act,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    localparam int LAST = STAGES - 1;
    localparam logic [2:0] PIN_RST = 3'b100;

    logic [2:0] chain_q [STAGES];
    logic [1:0] prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= PIN_RST;
                    else        chain_q[g] <= {cs_n, sck, si};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= PIN_RST;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= PIN_RST[2:1];
        else        prev_q <= chain_q[LAST][2:1];
    end

    assign cs_act   = !chain_q[LAST][2];
    assign cs_rise  = chain_q[LAST][2] && !prev_q[1];
    assign sck_rise = chain_q[LAST][1] && !prev_q[0];
    assign sck_fall = !chain_q[LAST][1] && prev_q[0];
    assign si_s     = chain_q[LAST][0];

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr,
    input  logic [PAGE_W-1:0]         idx,
    input  logic [7:0]                data,
    input  logic                      ok,
    output logic [(1<<PAGE_W)*8-1:0]  pdata,
    output logic [(1<<PAGE_W)-1:0]    pvalid
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    typedef struct packed {
        logic [PAGE_BYTES*8-1:0] bytes;
        logic [PAGE_BYTES-1:0]   valid;
    } pb_t;

    pb_t q, d;

    always_comb begin
        d = q;
        if (clr) d.valid = '0;
        if (wr) begin
            d.bytes[idx*8 +: 8] = data;
            d.valid[idx]        = ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pdata  = q.bytes;
    assign pvalid = q.valid;

    p_deny_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !ok) |=> !pvalid[$past(idx)]);

    p_clear_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !wr) |=> (pvalid == '0));

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_data,
    input  logic                          commit,
    input  logic [ADDR_W-PAGE_W-1:0]      page,
    input  logic [(1<<PAGE_W)*8-1:0]      pdata,
    input  logic [(1<<PAGE_W)-1:0]        pvalid
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvalid[i]) mem_q[{page, PAGE_W'(i)}] <= pdata[i*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 5,
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so_d,
    output logic              so_oe,
    output logic [ADDR_W-1:0] wp_addr,
    input  logic              wp_permit,
    output logic [1:0]        prot_lvl,
    output logic              prot_guard
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PNUM_W     = ADDR_W - PAGE_W;
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        phase_e             phase;
        logic [2:0]         bitc;
        logic               ahi;
        logic               is_wr;
        logic [15:0]        sr;
        logic [ADDR_W-1:0]  ptr;
        logic [2:0]         obit;
        logic               so;
        logic               oe;
        logic               wel;
        logic               busy;
        logic [CNT_W-1:0]   bcnt;
        logic               armed;
        logic               arm_page;
        logic               job_page;
        logic [PNUM_W-1:0]  jpage;
        logic [1:0]         lvl;
        logic               guard;
        logic [1:0]         new_lvl;
        logic               new_guard;
    } st_t;

    st_t q, n;

    logic cs_act, cs_rise, sck_rise, sck_fall, si_s;
    logic pb_clr, pb_wr;
    logic [PAGE_W-1:0] pb_idx;
    logic [7:0] pb_data;
    logic [PAGE_BYTES*8-1:0] pb_bytes;
    logic [PAGE_BYTES-1:0] pb_valid;
    logic arr_commit;
    logic [7:0] arr_rdata;
    logic [15:0] nsr;
    logic [7:0] op;
    logic [7:0] stat_byte;

    eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .cs_act(cs_act), .cs_rise(cs_rise), .sck_rise(sck_rise),
        .sck_fall(sck_fall), .si_s(si_s)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr), .idx(pb_idx),
        .data(pb_data), .ok(wp_permit), .pdata(pb_bytes), .pvalid(pb_valid)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(q.ptr), .rd_data(arr_rdata),
        .commit(arr_commit), .page(q.jpage), .pdata(pb_bytes), .pvalid(pb_valid)
    );

    assign stat_byte = {q.guard, 3'b000, q.lvl, q.wel, q.busy};

    always_comb begin
        n          = q;
        pb_clr     = 1'b0;
        pb_wr      = 1'b0;
        pb_idx     = q.ptr[PAGE_W-1:0];
        pb_data    = 8'h00;
        arr_commit = 1'b0;
        nsr        = {q.sr[14:0], si_s};
        op         = nsr[7:0];

        // busy period countdown and end-of-write actions
        if (q.busy) begin
            if (q.bcnt == CNT_W'(BUSY_CYCLES - 1)) begin
                n.busy = 1'b0;
                n.bcnt = '0;
                if (q.job_page) begin
                    arr_commit = 1'b1;
                end else begin
                    n.lvl   = q.new_lvl;
                    n.guard = q.new_guard;
                end
            end else begin
                n.bcnt = q.bcnt + 1'b1;
            end
        end

        if (cs_rise) begin
            // commit window: armed only between the last bit of a byte and the next rise
            if (q.armed) begin
                n.busy     = 1'b1;
                n.bcnt     = '0;
                n.wel      = 1'b0;
                n.job_page = q.arm_page;
                n.jpage    = q.ptr[ADDR_W-1:PAGE_W];
            end
            n.phase = PH_OPC;
            n.bitc  = 3'd0;
            n.ahi   = 1'b0;
            n.armed = 1'b0;
            n.oe    = 1'b0;
            n.obit  = 3'd0;
        end else if (cs_act && sck_rise) begin
            n.sr    = nsr;
            n.bitc  = q.bitc + 3'd1;
            n.armed = 1'b0;
            unique case (q.phase)
                PH_OPC: begin
                    if (q.bitc == 3'd7) begin
                        n.phase = PH_IGN;
                        if (!q.busy || op == CMD_STAT_RD) begin
                            unique case (op)
                                CMD_LATCH_SET: n.wel = 1'b1;
                                CMD_LATCH_CLR: n.wel = 1'b0;
                                CMD_READ: begin
                                    n.phase = PH_ADDR;
                                    n.is_wr = 1'b0;
                                end
                                CMD_WRITE: begin
                                    if (q.wel) begin
                                        n.phase = PH_ADDR;
                                        n.is_wr = 1'b1;
                                    end
                                end
                                CMD_STAT_RD: n.phase = PH_SRD;
                                CMD_STAT_WR: begin
                                    if (q.wel) n.phase = PH_SWR;
                                end
                                default: n.phase = PH_IGN;
                            endcase
                        end
                    end
                end
                PH_ADDR: begin
                    if (q.bitc == 3'd7) begin
                        if (!q.ahi) begin
                            n.ahi = 1'b1;
                        end else begin
                            n.ptr   = nsr[ADDR_W-1:0];
                            n.obit  = 3'd0;
                            n.phase = q.is_wr ? PH_WR : PH_RD;
                            pb_clr  = q.is_wr;
                        end
                    end
                end
                PH_WR: begin
                    if (q.bitc == 3'd7) begin
                        pb_wr      = 1'b1;
                        pb_data    = nsr[7:0];
                        n.ptr      = {q.ptr[ADDR_W-1:PAGE_W], q.ptr[PAGE_W-1:0] + 1'b1};
                        n.armed    = 1'b1;
                        n.arm_page = 1'b1;
                    end
                end
                PH_SWR: begin
                    if (q.bitc == 3'd7) begin
                        n.new_guard = nsr[7];
                        n.new_lvl   = nsr[3:2];
                        n.armed     = 1'b1;
                        n.arm_page  = 1'b0;
                        n.phase     = PH_IGN;
                    end
                end
                default: ;
            endcase
        end else if (cs_act && sck_fall) begin
            if (q.phase == PH_RD) begin
                n.so   = arr_rdata[3'd7 - q.obit];
                n.oe   = 1'b1;
                n.obit = q.obit + 3'd1;
                if (q.obit == 3'd7) n.ptr = q.ptr + 1'b1;
            end else if (q.phase == PH_SRD) begin
                n.so   = stat_byte[3'd7 - q.obit];
                n.oe   = 1'b1;
                n.obit = q.obit + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign so_d       = q.so;
    assign so_oe      = q.oe;
    assign wp_addr    = q.ptr;
    assign prot_lvl   = q.lvl;
    assign prot_guard = q.guard;

    p_out_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_d));

    p_oe_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !so_oe);

    p_latch_clear_on_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !q.wel);

    p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.bcnt < CNT_W'(BUSY_CYCLES)));

    p_busy_rejects_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && cs_act && !cs_rise && sck_rise && q.phase == PH_OPC &&
         q.bitc == 3'd7 && op != CMD_STAT_RD) |=> (q.phase == PH_IGN));

    p_status_apply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.busy) && !$past(q.job_page)) |-> (q.lvl == $past(q.new_lvl)));

endmodule

// File: tb/spi_eeprom_engine_tb.sv
module spi_eeprom_engine_tb;
    localparam int BUSY = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so_d, so_oe, wp_permit, prot_guard;
    logic [11:0] wp_addr;
    logic [1:0] prot_lvl;

    always #10 clk = ~clk;

    // protection unit model: top 256 bytes denied when any level is set
    assign wp_permit = !(prot_lvl != 2'b00 && wp_addr[11:8] == 4'hF);

    spi_eeprom_engine #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so_d(so_d), .so_oe(so_oe), .wp_addr(wp_addr), .wp_permit(wp_permit),
        .prot_lvl(prot_lvl), .prot_guard(prot_guard)
    );

    typedef struct { logic [7:0] v; string req; } item_t;
    item_t exp_q[$];
    item_t got_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic expect_val(input logic [7:0] v, input string req);
        item_t it; it.v = v; it.req = req; exp_q.push_back(it);
    endtask

    task automatic observe(input logic [7:0] v, input string req);
        item_t it; it.v = v; it.req = req; got_q.push_back(it);
    endtask

    // monitor: pops expected and observed items and compares them
    initial begin
        forever begin
            item_t e, g;
            wait (exp_q.size() > 0 && got_q.size() > 0);
            e = exp_q.pop_front();
            g = got_q.pop_front();
            checks++;
            if (g.v !== e.v) begin
                fails++;
                $display("FAIL %s: actual %02h expected %02h", e.req, g.v, e.v);
            end
        end
    end

    task automatic xfer(input logic [7:0] tx[$], input int extra, input bit idle_hi,
                        output logic [7:0] rx[$], output bit oe_any);
        logic [7:0] cur;
        rx = {};
        oe_any = 1'b0;
        cur = 8'h00;
        @(negedge clk);
        sck = idle_hi;
        repeat (4) @(negedge clk);
        si = 1'b1;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < tx.size() * 8 + extra; k++) begin
            sck = 1'b0;
            si = (k < tx.size() * 8) ? tx[k / 8][7 - (k % 8)] : 1'b0;
            repeat (4) @(negedge clk);
            cur = {cur[6:0], so_d};
            if (so_oe) oe_any = 1'b1;
            if (k % 8 == 7) rx.push_back(cur);
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        sck = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op, input int extra);
        logic [7:0] rx[$]; bit oe;
        xfer('{op}, extra, 1'b0, rx, oe);
    endtask

    task automatic stat_chk(input logic [7:0] e, input bit idle_hi, input string req);
        logic [7:0] rx[$]; bit oe;
        expect_val(e, req);
        xfer('{8'h05, 8'h00}, 0, idle_hi, rx, oe);
        observe(rx[1], req);
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [7:0] e[$], input bit idle_hi,
                            input string req);
        logic [7:0] tx[$]; logic [7:0] rx[$]; bit oe;
        tx = '{8'h03, {4'h0, a[11:8]}, a[7:0]};
        foreach (e[i]) begin
            tx.push_back(8'h00);
            expect_val(e[i], req);
        end
        xfer(tx, 0, idle_hi, rx, oe);
        for (int i = 3; i < rx.size(); i++) observe(rx[i], req);
    endtask

    task automatic write_bytes(input logic [11:0] a, input logic [7:0] d[$], input int extra);
        logic [7:0] tx[$]; logic [7:0] rx[$]; bit oe;
        tx = '{8'h02, {4'h0, a[11:8]}, a[7:0]};
        foreach (d[i]) tx.push_back(d[i]);
        xfer(tx, extra, 1'b0, rx, oe);
    endtask

    task automatic wait_busy();
        repeat (BUSY + 50) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx[$];
        logic [7:0] pg[$];
        bit oe;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        expect_val(8'h00, "R10 oe after reset"); observe({7'b0, so_oe}, "R10 oe after reset");
        expect_val(8'h00, "R10 prot after reset"); observe({5'b0, prot_guard, prot_lvl}, "R10 prot after reset");
        stat_chk(8'h00, 1'b0, "R10 status after reset");
        read_chk(12'h123, '{8'hFF}, 1'b0, "R10 erased byte");

        // R6: write without latch is ignored
        write_bytes(12'h045, '{8'h55}, 0);
        stat_chk(8'h00, 1'b0, "R6 no busy without latch");
        read_chk(12'h045, '{8'hFF}, 1'b0, "R6 array untouched");

        // R1: latch set / clear, extra clocks harmless
        cmd(8'h06, 0);
        stat_chk(8'h02, 1'b0, "R1 latch set");
        cmd(8'h04, 0);
        stat_chk(8'h00, 1'b0, "R1 latch clear");
        cmd(8'h06, 3);
        // R8: chip select falls with clock high, first bit on next rise
        stat_chk(8'h02, 1'b1, "R8 idle-high select then R1 extra clocks");

        // R5/R6/R7: committed write and busy behaviour
        write_bytes(12'h045, '{8'hA1, 8'hA2, 8'hA3}, 0);
        stat_chk(8'h01, 1'b0, "R7 busy bit with R6 latch cleared");
        expect_val(8'h00, "R7 read ignored while busy");
        xfer('{8'h03, 8'h00, 8'h45, 8'h00}, 0, 1'b0, rx, oe);
        observe({7'b0, oe}, "R7 read ignored while busy");
        cmd(8'h06, 0);
        wait_busy();
        stat_chk(8'h00, 1'b0, "R7 latch set ignored while busy");
        read_chk(12'h045, '{8'hA1, 8'hA2, 8'hA3, 8'hFF}, 1'b0, "R3 sequential read R5 commit");
        read_chk(12'h046, '{8'hA2}, 1'b1, "R2 idle-high clock read");

        // R4: wrap within page
        cmd(8'h06, 0);
        write_bytes(12'h07E, '{8'h11, 8'h22, 8'h33, 8'h44}, 0);
        wait_busy();
        read_chk(12'h07E, '{8'h11, 8'h22, 8'hFF}, 1'b0, "R4 page wrap next page untouched");
        read_chk(12'h060, '{8'h33, 8'h44}, 1'b0, "R4 wrapped bytes");

        // R4: 33 bytes overwrite the first slot
        pg = {};
        for (int k = 0; k < 33; k++) pg.push_back(8'(8'h40 + k));
        cmd(8'h06, 0);
        write_bytes(12'h100, pg, 0);
        wait_busy();
        read_chk(12'h100, '{8'h60, 8'h41}, 1'b0, "R4 overwrite on 33rd byte");

        // R5: cancellations
        cmd(8'h06, 0);
        write_bytes(12'h200, '{8'hAB}, 1);
        stat_chk(8'h02, 1'b0, "R5 extra bit cancels");
        write_bytes(12'h200, '{}, 0);
        stat_chk(8'h02, 1'b0, "R5 address only cancels");
        read_chk(12'h200, '{8'hFF}, 1'b0, "R5 cancelled data absent");

        // R3: wrap at top of array
        write_bytes(12'hFFF, '{8'h5A}, 0);
        wait_busy();
        read_chk(12'hFFF, '{8'h5A, 8'hFF}, 1'b0, "R3 wrap to address zero");

        // R11: status write
        cmd(8'h06, 0);
        xfer('{8'h01, 8'h8C}, 0, 1'b0, rx, oe);
        wait_busy();
        stat_chk(8'h8C, 1'b0, "R11 status written");
        expect_val(8'h07, "R11 protect outputs"); observe({5'b0, prot_guard, prot_lvl}, "R11 protect outputs");

        // R9: protection unit denies top region
        cmd(8'h06, 0);
        write_bytes(12'hF05, '{8'h77}, 0);
        wait_busy();
        stat_chk(8'h8C, 1'b0, "R6 latch cleared after denied write");
        read_chk(12'hF05, '{8'hFF}, 1'b0, "R9 denied byte not stored");
        cmd(8'h06, 0);
        write_bytes(12'h305, '{8'h77}, 0);
        wait_busy();
        read_chk(12'h305, '{8'h77}, 1'b0, "R9 permitted byte stored");

        wait (exp_q.size() == 0 && got_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule